// File: doc/BRIEF.md
# Controller Start-Up Sequencer

This block is a small AXI4-Lite master that starts a streaming transmit controller after a reset. It issues a fixed series of accesses to a single control register. First it writes a soft-reset command. Next it reads the register over and over until the ready status bit is set, waiting a fixed number of cycles between reads. Only after that does it write the enable command. The order is not optional: if the enable is written before the controller reports ready, the controller stalls and keeps its stream input blocked.

When the enable write has been acknowledged, the sequencer raises `init_ready_o`. Logic further along uses that flag to decide when pixel streaming may begin. Any of the following stops the sequence for good and raises `init_error_o`:

- a write response other than OKAY,
- a read response other than OKAY,
- a poll phase that lasts past a programmable cycle budget.

Both flags keep their value until the next reset.

Top module: `ctrl_boot_seq`

## Requirements
- R1: The first transaction after reset is a write to address 0x00 with data 0x12, presented with all four strobe bits set.
- R2: Status reads go to address 0x00 and start only after the soft-reset write has received its response. A read counts as ready only when bit 2 of its data is 1 and its response is OKAY. All other data bits are ignored.
- R3: After a read response that is OKAY but not ready, the next read address is presented after exactly POLL_GAP+1 cycles with the read address valid low. This is POLL_GAP waiting cycles plus one launch cycle.
- R4: The enable write (data 0x11, address 0x00) is issued exactly once. It is issued only after a ready read, and it is never issued if no ready read was returned.
- R5: A write presents its address valid and its data valid in the same cycle. Each valid stays high, with its payload unchanged, until its ready is sampled high. The address and data channels may be accepted in either order.
- R6: The response ready signal is high while a write address or data valid is pending. Read data ready is high while a read address valid is pending.
- R7: `init_ready_o` rises in the cycle after the enable write's OKAY response is accepted. It then stays high until reset, and no further transactions are issued.
- R8: A non-OKAY write or read response (for example 2'b10) raises `init_error_o` in the next cycle. From then on `init_ready_o` stays low and no further transactions are issued.
- R9: If no ready read arrives, `init_error_o` rises no sooner than POLL_TIMEOUT cycles after the soft-reset write completes. It rises only between reads, and the enable write is never issued.
- R10: While `rst_ni` is low, all valid outputs and both flags are low. After reset is released, the sequence starts again from R1.
- R11: `init_ready_o` and `init_error_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awaddr_o | output | 8 | Write address |
| awvalid_o | output | 1 | Write address valid |
| awready_i | input | 1 | Write address ready |
| wdata_o | output | 32 | Write data |
| wstrb_o | output | 4 | Write byte strobes |
| wvalid_o | output | 1 | Write data valid |
| wready_i | input | 1 | Write data ready |
| bresp_i | input | 2 | Write response code |
| bvalid_i | input | 1 | Write response valid |
| bready_o | output | 1 | Write response ready |
| araddr_o | output | 8 | Read address |
| arvalid_o | output | 1 | Read address valid |
| arready_i | input | 1 | Read address ready |
| rdata_i | input | 32 | Read data |
| rresp_i | input | 2 | Read response code |
| rvalid_i | input | 1 | Read data valid |
| rready_o | output | 1 | Read data ready |
| init_ready_o | output | 1 | Controller enabled; streaming may start |
| init_error_o | output | 1 | Start-up failed (bad response or timeout) |

## Verification
The assertions assume the slave follows the protocol:

- it raises a write response only after it has accepted both the write address and the write data;
- it returns read data only after it has accepted the read address;
- it keeps each of its own valids asserted until the sequencer accepts it.

The bench stimulus follows these rules by construction. Its slave model raises a response only once the matching acceptances are recorded, and it holds each response valid until the cycle in which the ready is high. Acceptance latencies differ from case to case, so that the write address lands both before and after the write data.

// File: rtl/ctrl_boot_pkg.sv
package ctrl_boot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRST,
    ST_POLL,
    ST_GAP,
    ST_ENABLE,
    ST_LIVE,
    ST_FAULT
  } boot_state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/ctrl_boot_wr.sv
module ctrl_boot_wr #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] awaddr_o,
  output logic              awvalid_o,
  input  logic              awready_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W/8-1:0] wstrb_o,
  output logic              wvalid_o,
  input  logic              wready_i,
  input  logic [1:0]        bresp_i,
  input  logic              bvalid_i,
  output logic              bready_o,
  output logic              done_o,
  output logic              fail_o
);
  import ctrl_boot_pkg::*;

  localparam int STRB_W = DATA_W / 8;

  logic              busy_q;
  logic              aw_pend_q;
  logic              w_pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // response accepted only while a write is open
  assign done_o = busy_q & bvalid_i;
  assign fail_o = done_o & (bresp_i != RESP_OKAY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      aw_pend_q <= 1'b0;
      w_pend_q  <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else if (!busy_q) begin
      if (req_i) begin
        busy_q    <= 1'b1;
        aw_pend_q <= 1'b1;
        w_pend_q  <= 1'b1;
        addr_q    <= addr_i;
        data_q    <= data_i;
      end
    end else begin
      if (aw_pend_q && awready_i) aw_pend_q <= 1'b0;
      if (w_pend_q && wready_i)   w_pend_q  <= 1'b0;
      if (done_o)                 busy_q    <= 1'b0;
    end
  end

  assign awaddr_o  = addr_q;
  assign awvalid_o = aw_pend_q;
  assign wdata_o   = data_q;
  assign wstrb_o   = {STRB_W{1'b1}};
  assign wvalid_o  = w_pend_q;
  assign bready_o  = busy_q;

endmodule

// File: rtl/ctrl_boot_rd.sv
module ctrl_boot_rd #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int READY_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] araddr_o,
  output logic              arvalid_o,
  input  logic              arready_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [1:0]        rresp_i,
  input  logic              rvalid_i,
  output logic              rready_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              status_o
);
  import ctrl_boot_pkg::*;

  logic              busy_q;
  logic              ar_pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic              unused_rdata;

  assign unused_rdata = ^rdata_i;

  assign done_o   = busy_q & rvalid_i;
  assign fail_o   = done_o & (rresp_i != RESP_OKAY);
  assign status_o = rdata_i[READY_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      ar_pend_q <= 1'b0;
      addr_q    <= '0;
    end else if (!busy_q) begin
      if (req_i) begin
        busy_q    <= 1'b1;
        ar_pend_q <= 1'b1;
        addr_q    <= addr_i;
      end
    end else begin
      if (ar_pend_q && arready_i) ar_pend_q <= 1'b0;
      if (done_o)                 busy_q    <= 1'b0;
    end
  end

  assign araddr_o  = addr_q;
  assign arvalid_o = ar_pend_q;
  assign rready_o  = busy_q;

endmodule

// File: rtl/ctrl_boot_fsm.sv
module ctrl_boot_fsm #(
  parameter int          DATA_W       = 32,
  parameter int          POLL_GAP     = 10,
  parameter int          POLL_TIMEOUT = 125000,
  parameter logic [31:0] RESET_CMD    = 32'h12,
  parameter logic [31:0] ENABLE_CMD   = 32'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_done_i,
  input  logic              wr_fail_i,
  input  logic              rd_done_i,
  input  logic              rd_fail_i,
  input  logic              rd_status_i,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic              init_ready_o,
  output logic              init_error_o
);
  import ctrl_boot_pkg::*;

  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam int TMO_W = $clog2(POLL_TIMEOUT + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(POLL_GAP - 1);
  localparam logic [TMO_W-1:0] TMO_LIM  = TMO_W'(POLL_TIMEOUT);

  boot_state_e      state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [TMO_W-1:0] poll_q, poll_d;

  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    poll_d  = poll_q;
    unique case (state_q)
      ST_IDLE: state_d = ST_SRST;
      ST_SRST: begin
        if (wr_done_i) begin
          state_d = wr_fail_i ? ST_FAULT : ST_POLL;
          poll_d  = '0;
        end
      end
      ST_POLL: begin
        if (poll_q != TMO_LIM) poll_d = poll_q + 1'b1;
        if (rd_done_i) begin
          gap_d = '0;
          if (rd_fail_i)        state_d = ST_FAULT;
          else if (rd_status_i) state_d = ST_ENABLE;
          else                  state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        // timeout only checked with no read outstanding
        if (poll_q != TMO_LIM) poll_d = poll_q + 1'b1;
        gap_d = gap_q + 1'b1;
        if (poll_q >= TMO_LIM)   state_d = ST_FAULT;
        else if (gap_q == GAP_LAST) state_d = ST_POLL;
      end
      ST_ENABLE: begin
        if (wr_done_i) state_d = wr_fail_i ? ST_FAULT : ST_LIVE;
      end
      ST_LIVE:  state_d = ST_LIVE;
      ST_FAULT: state_d = ST_FAULT;
      default:  state_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gap_q   <= '0;
      poll_q  <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
      poll_q  <= poll_d;
    end
  end

  assign wr_req_o     = (state_q == ST_SRST) || (state_q == ST_ENABLE);
  assign wr_data_o    = (state_q == ST_ENABLE) ? DATA_W'(ENABLE_CMD) : DATA_W'(RESET_CMD);
  assign rd_req_o     = (state_q == ST_POLL);
  assign init_ready_o = (state_q == ST_LIVE);
  assign init_error_o = (state_q == ST_FAULT);

endmodule

// File: rtl/ctrl_boot_seq.sv
module ctrl_boot_seq #(
  parameter int              ADDR_W       = 8,
  parameter int              DATA_W       = 32,
  parameter int              READY_BIT    = 2,
  parameter int              POLL_GAP     = 10,
  parameter int              POLL_TIMEOUT = 125000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = '0,
  parameter logic [31:0]     RESET_CMD    = 32'h12,
  parameter logic [31:0]     ENABLE_CMD   = 32'h11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [ADDR_W-1:0]   awaddr_o,
  output logic                awvalid_o,
  input  logic                awready_i,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [DATA_W/8-1:0] wstrb_o,
  output logic                wvalid_o,
  input  logic                wready_i,
  input  logic [1:0]          bresp_i,
  input  logic                bvalid_i,
  output logic                bready_o,
  output logic [ADDR_W-1:0]   araddr_o,
  output logic                arvalid_o,
  input  logic                arready_i,
  input  logic [DATA_W-1:0]   rdata_i,
  input  logic [1:0]          rresp_i,
  input  logic                rvalid_i,
  output logic                rready_o,
  output logic                init_ready_o,
  output logic                init_error_o
);

  logic              wr_req, wr_done, wr_fail;
  logic              rd_req, rd_done, rd_fail, rd_status;
  logic [DATA_W-1:0] wr_data;

  ctrl_boot_fsm #(
    .DATA_W      (DATA_W),
    .POLL_GAP    (POLL_GAP),
    .POLL_TIMEOUT(POLL_TIMEOUT),
    .RESET_CMD   (RESET_CMD),
    .ENABLE_CMD  (ENABLE_CMD)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_done_i   (wr_done),
    .wr_fail_i   (wr_fail),
    .rd_done_i   (rd_done),
    .rd_fail_i   (rd_fail),
    .rd_status_i (rd_status),
    .wr_req_o    (wr_req),
    .wr_data_o   (wr_data),
    .rd_req_o    (rd_req),
    .init_ready_o(init_ready_o),
    .init_error_o(init_error_o)
  );

  ctrl_boot_wr #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (wr_req),
    .addr_i   (CTRL_ADDR),
    .data_i   (wr_data),
    .awaddr_o (awaddr_o),
    .awvalid_o(awvalid_o),
    .awready_i(awready_i),
    .wdata_o  (wdata_o),
    .wstrb_o  (wstrb_o),
    .wvalid_o (wvalid_o),
    .wready_i (wready_i),
    .bresp_i  (bresp_i),
    .bvalid_i (bvalid_i),
    .bready_o (bready_o),
    .done_o   (wr_done),
    .fail_o   (wr_fail)
  );

  ctrl_boot_rd #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .READY_BIT(READY_BIT)
  ) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (rd_req),
    .addr_i   (CTRL_ADDR),
    .araddr_o (araddr_o),
    .arvalid_o(arvalid_o),
    .arready_i(arready_i),
    .rdata_i  (rdata_i),
    .rresp_i  (rresp_i),
    .rvalid_i (rvalid_i),
    .rready_o (rready_o),
    .done_o   (rd_done),
    .fail_o   (rd_fail),
    .status_o (rd_status)
  );

endmodule

// File: rtl/ctrl_boot_seq_sva.sv
module ctrl_boot_seq_sva #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   awaddr_o,
  input logic                awvalid_o,
  input logic                awready_i,
  input logic [DATA_W-1:0]   wdata_o,
  input logic                wvalid_o,
  input logic                wready_i,
  input logic                bready_o,
  input logic [ADDR_W-1:0]   araddr_o,
  input logic                arvalid_o,
  input logic                arready_i,
  input logic                rready_o,
  input logic                init_ready_o,
  input logic                init_error_o
);

  p_aw_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid_o && !awready_i |=> awvalid_o && $stable(awaddr_o));

  p_w_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o && !wready_i |=> wvalid_o && $stable(wdata_o));

  p_ar_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_o && !arready_i |=> arvalid_o && $stable(araddr_o));

  p_aw_with_w_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(awvalid_o) |-> wvalid_o);

  p_bready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awvalid_o || wvalid_o) |-> bready_o);

  p_rready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_o |-> rready_o);

  p_ready_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_ready_o |=> init_ready_o && !awvalid_o && !arvalid_o);

  p_error_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_error_o |=> init_error_o && !awvalid_o && !arvalid_o);

  p_flags_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(init_ready_o && init_error_o));

endmodule

bind ctrl_boot_seq ctrl_boot_seq_sva #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .awaddr_o    (awaddr_o),
  .awvalid_o   (awvalid_o),
  .awready_i   (awready_i),
  .wdata_o     (wdata_o),
  .wvalid_o    (wvalid_o),
  .wready_i    (wready_i),
  .bready_o    (bready_o),
  .araddr_o    (araddr_o),
  .arvalid_o   (arvalid_o),
  .arready_i   (arready_i),
  .rready_o    (rready_o),
  .init_ready_o(init_ready_o),
  .init_error_o(init_error_o)
);

// File: tb/ctrl_boot_seq_test.sv
`timescale 1ns/1ps
module ctrl_boot_seq_test;

  localparam int GAP = 10;
  localparam int TMO = 400;
  localparam int WD_CYCLES = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  awaddr_o, araddr_o;
  logic        awvalid_o, wvalid_o, bready_o, arvalid_o, rready_o;
  logic [31:0] wdata_o;
  logic [3:0]  wstrb_o;
  logic        awready_i = 0, wready_i = 0, bvalid_i = 0, arready_i = 0, rvalid_i = 0;
  logic [1:0]  bresp_i = 0, rresp_i = 0;
  logic [31:0] rdata_i = 0;
  logic        init_ready_o, init_error_o;

  always #4 clk_i = ~clk_i;

  ctrl_boot_seq #(.POLL_GAP(GAP), .POLL_TIMEOUT(TMO)) uut (
    .clk_i, .rst_ni,
    .awaddr_o, .awvalid_o, .awready_i,
    .wdata_o, .wstrb_o, .wvalid_o, .wready_i,
    .bresp_i, .bvalid_i, .bready_o,
    .araddr_o, .arvalid_o, .arready_i,
    .rdata_i, .rresp_i, .rvalid_i, .rready_o,
    .init_ready_o, .init_error_o
  );

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  // scenario knobs
  int rdy_after, aw_lat, w_lat, b_lat, ar_lat, r_lat, bad_b, bad_r;
  bit tmo_mode;

  // slave state
  bit aw_taken, w_taken, ar_taken;
  int aw_ctr, w_ctr, b_ctr, ar_ctr, r_ctr;
  int writes_done, reads_done, w_count, en_count;
  logic [31:0] first_wdata, last_wdata;

  // reference model
  bit exp_ready, exp_err, ready_seen;
  int t_rst_done;
  bit gap_arm;
  int gap_cnt;
  bit p_awv, p_awr, p_wv, p_wr, p_arv, p_arr;
  logic [7:0]  p_awaddr, p_araddr;
  logic [31:0] p_wdata;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic clear_state();
    aw_taken = 0; w_taken = 0; ar_taken = 0;
    aw_ctr = 0; w_ctr = 0; b_ctr = 0; ar_ctr = 0; r_ctr = 0;
    writes_done = 0; reads_done = 0; w_count = 0; en_count = 0;
    first_wdata = 0; last_wdata = 0;
    exp_ready = 0; exp_err = 0; ready_seen = 0; t_rst_done = 0;
    gap_arm = 0; gap_cnt = 0;
    p_awv = 0; p_awr = 0; p_wv = 0; p_wr = 0; p_arv = 0; p_arr = 0;
    p_awaddr = 0; p_araddr = 0; p_wdata = 0;
    awready_i = 0; wready_i = 0; bvalid_i = 0; arready_i = 0; rvalid_i = 0;
    bresp_i = 0; rresp_i = 0; rdata_i = 0;
  endtask

  task automatic tick();
    bit hs_aw, hs_w, hs_b, hs_ar, hs_r;
    @(negedge clk_i);
    cyc++;
    if (!rst_ni) begin
      check(!awvalid_o && !wvalid_o && !arvalid_o && !init_ready_o && !init_error_o,
            "R10", "outputs in reset",
            {27'b0, awvalid_o, wvalid_o, arvalid_o, init_ready_o, init_error_o}, 32'h0);
      clear_state();
      return;
    end
    // per-cycle comparison against the model
    check(init_ready_o == exp_ready, "R7", "init_ready", init_ready_o, exp_ready);
    if (!tmo_mode) begin
      check(init_error_o == exp_err, "R8", "init_error", init_error_o, exp_err);
    end else if (init_error_o && !exp_err) begin
      check((cyc - t_rst_done >= TMO) && (cyc - t_rst_done <= TMO + GAP + 20),
            "R9", "timeout delay", cyc - t_rst_done, TMO);
      exp_err = 1;
    end else if (!init_error_o && exp_err) begin
      check(0, "R9", "error dropped", 0, 1);
    end
    check(!(init_ready_o && init_error_o), "R11", "flags exclusive", {init_ready_o, init_error_o}, 0);
    if (exp_ready) check(!awvalid_o && !arvalid_o, "R7", "quiet after ready", {awvalid_o, arvalid_o}, 0);
    if (exp_err)   check(!awvalid_o && !arvalid_o, "R8", "quiet after error", {awvalid_o, arvalid_o}, 0);
    if (p_awv && !p_awr) check(awvalid_o && awaddr_o == p_awaddr, "R5", "aw hold", awvalid_o, 1);
    if (p_wv && !p_wr)   check(wvalid_o && wdata_o == p_wdata, "R5", "w hold", wdata_o, p_wdata);
    if (p_arv && !p_arr) check(arvalid_o && araddr_o == p_araddr, "R5", "ar hold", arvalid_o, 1);
    if (awvalid_o && !p_awv) check(wvalid_o, "R5", "aw and w together", wvalid_o, 1);
    if (awvalid_o || wvalid_o) check(bready_o, "R6", "bready during write", bready_o, 1);
    if (arvalid_o) check(rready_o, "R6", "rready during read", rready_o, 1);
    if (gap_arm) begin
      if (arvalid_o) begin
        check(gap_cnt == GAP + 1, "R3", "poll gap", gap_cnt, GAP + 1);
        gap_arm = 0;
      end else begin
        gap_cnt++;
      end
    end

    // slave drive
    awready_i = awvalid_o && !aw_taken && aw_ctr >= aw_lat;
    wready_i  = wvalid_o && !w_taken && w_ctr >= w_lat;
    bvalid_i  = aw_taken && w_taken && b_ctr >= b_lat;
    bresp_i   = (writes_done == bad_b) ? 2'b10 : 2'b00;
    arready_i = arvalid_o && !ar_taken && ar_ctr >= ar_lat;
    rvalid_i  = ar_taken && r_ctr >= r_lat;
    rresp_i   = (reads_done == bad_r) ? 2'b10 : 2'b00;
    rdata_i   = (reads_done >= rdy_after) ? 32'h0000_0004 : 32'hFFFF_FFFB;

    hs_aw = awvalid_o && awready_i;
    hs_w  = wvalid_o && wready_i;
    hs_b  = bvalid_i && bready_o;
    hs_ar = arvalid_o && arready_i;
    hs_r  = rvalid_i && rready_o;

    if (hs_aw) check(awaddr_o == 8'h00, "R1", "write address", awaddr_o, 0);
    if (hs_w) begin
      check(wstrb_o == 4'hF, "R1", "strobes", wstrb_o, 4'hF);
      if (w_count == 0) begin
        check(wdata_o == 32'h12, "R1", "first write data", wdata_o, 32'h12);
        first_wdata = wdata_o;
      end
      if (wdata_o == 32'h11) begin
        check(ready_seen, "R4", "enable before ready", ready_seen, 1);
        en_count++;
      end
      last_wdata = wdata_o;
      w_count++;
    end
    if (hs_ar) begin
      check(araddr_o == 8'h00, "R2", "read address", araddr_o, 0);
      check(writes_done >= 1, "R2", "read before reset write done", writes_done, 1);
    end
    if (hs_b) begin
      if (bresp_i != 2'b00) exp_err = 1;
      else if (last_wdata == 32'h11) exp_ready = 1;
      if (writes_done == 0) t_rst_done = cyc;
    end
    if (hs_r) begin
      if (rresp_i != 2'b00) exp_err = 1;
      else if (rdata_i[2]) ready_seen = 1;
      else begin
        gap_arm = 1;
        gap_cnt = 0;
      end
    end

    // slave state update
    aw_ctr = (awvalid_o && !aw_taken && !hs_aw) ? aw_ctr + 1 : 0;
    w_ctr  = (wvalid_o && !w_taken && !hs_w) ? w_ctr + 1 : 0;
    ar_ctr = (arvalid_o && !ar_taken && !hs_ar) ? ar_ctr + 1 : 0;
    if (aw_taken && w_taken) b_ctr++;
    if (ar_taken) r_ctr++;
    if (hs_aw) aw_taken = 1;
    if (hs_w)  w_taken = 1;
    if (hs_ar) begin ar_taken = 1; r_ctr = 0; end
    if (hs_b) begin aw_taken = 0; w_taken = 0; b_ctr = 0; writes_done++; end
    if (hs_r) begin ar_taken = 0; r_ctr = 0; reads_done++; end

    p_awv = awvalid_o; p_awr = awready_i; p_awaddr = awaddr_o;
    p_wv  = wvalid_o;  p_wr  = wready_i;  p_wdata  = wdata_o;
    p_arv = arvalid_o; p_arr = arready_i; p_araddr = araddr_o;
  endtask

  task automatic run_case(string name, int rdy, int awl, int wl, int bl, int arl, int rl,
                          int badb, int badr, bit tmo, bit exp_done, int exp_w, int exp_r,
                          int abort_after);
    bit ended;
    int tail;
    rst_ni = 0;
    for (int i = 0; i < 3; i++) tick();
    rdy_after = rdy; aw_lat = awl; w_lat = wl; b_lat = bl; ar_lat = arl; r_lat = rl;
    bad_b = badb; bad_r = badr; tmo_mode = tmo;
    rst_ni = 1;
    ended = 0;
    tail = 0;
    for (int i = 0; i < 3000 && tail < 20; i++) begin
      tick();
      if (abort_after >= 0 && reads_done >= abort_after) begin
        rst_ni = 0;
        #1;
        check(!awvalid_o && !wvalid_o && !arvalid_o && !init_ready_o && !init_error_o,
              "R10", {name, " async reset"}, {awvalid_o, wvalid_o, arvalid_o}, 0);
        return;
      end
      if (init_ready_o || init_error_o) ended = 1;
      if (ended) tail++;
    end
    check(init_ready_o == exp_done, "R7", {name, " final ready"}, init_ready_o, exp_done);
    check(init_error_o == !exp_done, "R8", {name, " final error"}, init_error_o, !exp_done);
    check(w_count == exp_w, "R4", {name, " write count"}, w_count, exp_w);
    check(en_count == (exp_done ? 1 : (exp_w == 2 ? 1 : 0)), "R4", {name, " enable count"},
          en_count, exp_done ? 1 : 0);
    if (exp_r >= 0) check(reads_done == exp_r, "R2", {name, " read count"}, reads_done, exp_r);
    if (tmo) check(reads_done > 1 && en_count == 0, "R9", {name, " polled without enable"},
                   reads_done, 2);
  endtask

  initial begin
    #(WD_CYCLES * 8);
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors + 1, n_checks + 1);
    $finish;
  end

  initial begin
    clear_state();
    rdy_after = 0; aw_lat = 0; w_lat = 0; b_lat = 0; ar_lat = 0; r_lat = 0;
    bad_b = -1; bad_r = -1; tmo_mode = 0;
    // name rdy awl wl bl arl rl badb badr tmo done W R abort
    run_case("basic",       3, 0, 0, 0, 0, 0, -1, -1, 0, 1, 2, 4, -1);
    run_case("w_first",     0, 3, 0, 2, 2, 3, -1, -1, 0, 1, 2, 1, -1);
    run_case("aw_first",    5, 0, 4, 1, 0, 1, -1, -1, 0, 1, 2, 6, -1);
    run_case("bad_bresp",   0, 1, 1, 1, 0, 0,  0, -1, 0, 0, 1, 0, -1);
    run_case("bad_rresp",   4, 0, 0, 0, 1, 1, -1,  1, 0, 0, 1, 2, -1);
    run_case("bad_enable",  1, 0, 0, 1, 0, 0,  1, -1, 0, 0, 2, 2, -1);
    run_case("timeout", 100000, 0, 0, 0, 0, 2, -1, -1, 1, 0, 1, -1, -1);
    run_case("abort",       3, 0, 0, 0, 0, 0, -1, -1, 0, 1, 2, 4, 2);
    run_case("restart",     2, 1, 2, 1, 1, 2, -1, -1, 0, 1, 2, 3, -1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule